// File: doc/BRIEF.md
# Clock Mode Control Register

This block is the 8-bit control register that steers an on-chip clock generator. Software writes it over a simple register bus made of a write strobe, write data and read data. The register sets the oscillator drive strength, the reference frequency range, the external reference type, two monitor controls and a 2-bit request for the clock mode. It also guards its own fields. Two fields can be set only once after reset. The first mode write can lock out every external-reference mode until the next reset. A new mode request is refused while an earlier mode change is still in flight.

The oscillator, the frequency-locked loop and the clock multiplexer are outside the block. Each one appears only as a handshake input. `switch_done` pulses when a mode switch has finished, and `ext_ready` shows that the external reference is usable. A bypassed-external request is not applied until `ext_ready` is 1. `stop_req` freezes mode transitions and leaves the stored contents as they are. The block outputs the mode that is actually in force and the loop prescale factor that goes with it.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 8'h44, `active_mode` is 00 and `mode_pending` is 0. Bit 0 always reads 0.
- R2: Bit 7 (oscillator gain, 1 = high amplitude), bit 2 (oscillator-stop enable) and bit 1 (loss-of-clock disable) take the write data on the clock edge that samples `wr_en`. Bit 0 ignores writes.
- R3: Bit 6 (range) and bit 5 (external reference select) take only the first write after reset. Later writes leave them unchanged.
- R4: If the first write after reset carries bit 4 = 0, every later write with bit 4 = 1 leaves the mode field (bits 4:3) unchanged until the next reset. If the first write carries bit 4 = 1, no lock is applied.
- R5: The mode field is bits 4:3 with the encoding 00 self-clocked, 01 loop on internal reference, 10 loop bypassed on external reference, 11 loop on external reference. An accepted write whose mode differs from `active_mode` sets `mode_pending` at that edge. A write whose mode equals `active_mode` does not set it.
- R6: While `mode_pending` is 1, writes leave the mode field unchanged. The other fields still follow R2 and R3.
- R7: For a pending request other than 10, a `switch_done` of 1 at an edge moves the requested mode into `active_mode` and clears `mode_pending` at that edge.
- R8: A pending request for 10 completes only at an edge where `ext_ready` is 1. `switch_done` has no effect on it.
- R9: While `stop_req` is 1, no pending change completes, and the register contents stay as they are.
- R10: `prescale` is 64 when `active_mode` is 10 or 11 and range is 0. It is 1 when range is 1 or when `active_mode` is 00 or 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| ext_ready | input | 1 | External reference is usable |
| switch_done | input | 1 | Pulse: the clock generator has finished a mode switch |
| stop_req | input | 1 | Freeze mode transitions |
| rd_data | output | 8 | Stored register value |
| active_mode | output | 2 | Clock mode currently in force |
| mode_pending | output | 1 | A mode change is awaiting completion |
| prescale | output | 7 | Loop prescale factor |

## Verification
The write patterns are chosen to separate the guarded fields from the free ones. One write sets bit 0 and changes the free bits together with the write-once bits, which shows which fields actually moved. Two reset sequences are run: one whose first mode write has bit 4 clear and one whose first mode write has bit 4 set. A later write of mode 11 then distinguishes a locked register from an unlocked one. The completion inputs are applied in mismatched pairs, so that a wrong handshake cannot complete a change: `switch_done` is raised against a bypass request, and `switch_done` is raised under `stop_req`. A write is also issued while a change is pending, which shows that the interlock blocks only the mode field.

// File: rtl/ckm_pkg.sv
// Shared types and field positions for the clock mode control register.
// Assumes an 8-bit register; positions are fixed because software decodes them.
package ckm_pkg;
    localparam int DATA_W    = 8;
    localparam int BIT_GAIN  = 7;
    localparam int BIT_RANGE = 6;
    localparam int BIT_REFS  = 5;
    localparam int BIT_MODE  = 3;   // mode occupies BIT_MODE+1 : BIT_MODE
    localparam int BIT_OSTOP = 2;
    localparam int BIT_LOCD  = 1;
    localparam logic [DATA_W-1:0] RESET_VALUE = 8'h44;

    localparam int ONCE_N = 2;
    localparam int ONCE_POS [ONCE_N] = '{BIT_RANGE, BIT_REFS};

    typedef enum logic [1:0] {
        MODE_SELF    = 2'b00,
        MODE_FLL_INT = 2'b01,
        MODE_BYP_EXT = 2'b10,
        MODE_FLL_EXT = 2'b11
    } ckm_mode_e;
endpackage

// File: rtl/ckm_once_bit.sv
// One register bit that accepts only the first write after reset.
// Assumes wr_en is a single-cycle-or-longer strobe; any write counts as "first".
module ckm_once_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic q
);
    logic taken;

    // Latch the first written value, then hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= RST_VAL;
            taken <= 1'b0;
        end else if (wr_en && !taken) begin
            q     <= wr_bit;
            taken <= 1'b1;
        end
    end
endmodule

// File: rtl/ckm_mode_gate.sv
// Holds the requested mode field and decides whether a write may change it.
// Assumes busy reflects a pending change; the first unblocked write sets the lock.
module ckm_mode_gate
    import ckm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [1:0] wr_mode,
    input  logic      busy,
    output logic      accept,
    output ckm_mode_e mode_q
);
    logic first_seen;
    logic ext_locked;

    // A write is taken unless a change is in flight or external modes are locked out.
    always_comb begin
        accept = wr_en && !busy && !(ext_locked && wr_mode[1]);
    end

    // Store the mode field and record the lock chosen by the first write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_SELF;
            first_seen <= 1'b0;
            ext_locked <= 1'b0;
        end else begin
            if (accept) begin
                mode_q <= ckm_mode_e'(wr_mode);
            end
            if (wr_en && !busy && !first_seen) begin
                first_seen <= 1'b1;
                ext_locked <= ~wr_mode[1];
            end
        end
    end
endmodule

// File: rtl/ckm_mode_track.sv
// Tracks the active clock mode and the pending-change flag.
// Assumes new_mode is the value the gate stores on accept, and req_mode the stored field.
module ckm_mode_track
    import ckm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  logic [1:0] new_mode,
    input  ckm_mode_e req_mode,
    input  logic      stop_req,
    input  logic      ext_ready,
    input  logic      switch_done,
    output ckm_mode_e active,
    output logic      pending
);
    logic finish;

    // Completion: bypass waits for the external reference, others for the switch handshake.
    always_comb begin
        if (req_mode == MODE_BYP_EXT) finish = pending && !stop_req && ext_ready;
        else                          finish = pending && !stop_req && switch_done;
    end

    // Update the active mode on completion; raise pending on a differing accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= MODE_SELF;
            pending <= 1'b0;
        end else if (finish) begin
            active  <= req_mode;
            pending <= 1'b0;
        end else if (accept && (new_mode != active)) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/clk_mode_ctrl.sv
// Top of the clock mode control register: free, write-once and guarded mode fields,
// active-mode tracking and prescale selection. Assumes a synchronous register bus.
module clk_mode_ctrl
    import ckm_pkg::*;
#(
    parameter int PRESCALE_LO = 64,
    parameter int PRESCALE_HI = 1,
    localparam int PS_W = $clog2(PRESCALE_LO + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_ready,
    input  logic              switch_done,
    input  logic              stop_req,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        active_mode,
    output logic              mode_pending,
    output logic [PS_W-1:0]   prescale
);
    logic              gain_q;
    logic              ostop_q;
    logic              locd_q;
    logic [ONCE_N-1:0] once_q;
    logic              accept;
    ckm_mode_e         mode_q;
    ckm_mode_e         active_q;
    logic              pend_q;
    logic              unused_bit0;

    assign unused_bit0 = wr_data[0];

    // Freely writable bits follow the bus on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q  <= RESET_VALUE[BIT_GAIN];
            ostop_q <= RESET_VALUE[BIT_OSTOP];
            locd_q  <= RESET_VALUE[BIT_LOCD];
        end else if (wr_en) begin
            gain_q  <= wr_data[BIT_GAIN];
            ostop_q <= wr_data[BIT_OSTOP];
            locd_q  <= wr_data[BIT_LOCD];
        end
    end

    // Write-once bits, one instance per listed position.
    for (genvar i = 0; i < ONCE_N; i++) begin : g_once
        ckm_once_bit #(
            .RST_VAL (RESET_VALUE[ONCE_POS[i]])
        ) u_once (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_bit (wr_data[ONCE_POS[i]]),
            .q      (once_q[i])
        );
    end

    ckm_mode_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_mode (wr_data[BIT_MODE+1:BIT_MODE]),
        .busy    (pend_q),
        .accept  (accept),
        .mode_q  (mode_q)
    );

    ckm_mode_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .new_mode    (wr_data[BIT_MODE+1:BIT_MODE]),
        .req_mode    (mode_q),
        .stop_req    (stop_req),
        .ext_ready   (ext_ready),
        .switch_done (switch_done),
        .active      (active_q),
        .pending     (pend_q)
    );

    // Assemble the read view from the stored fields; bit 0 is reserved.
    always_comb begin
        rd_data                       = '0;
        rd_data[BIT_GAIN]             = gain_q;
        rd_data[BIT_RANGE]            = once_q[0];
        rd_data[BIT_REFS]             = once_q[1];
        rd_data[BIT_MODE+1:BIT_MODE]  = mode_q;
        rd_data[BIT_OSTOP]            = ostop_q;
        rd_data[BIT_LOCD]             = locd_q;
    end

    // Range picks the prescale only in the external-reference modes.
    always_comb begin
        if (active_q[1] && !once_q[0]) prescale = PS_W'(PRESCALE_LO);
        else                           prescale = PS_W'(PRESCALE_HI);
    end

    assign active_mode  = active_q;
    assign mode_pending = pend_q;
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
// Port-level assertions for clk_mode_ctrl, attached by bind.
// Assumes the default 7-bit prescale width; keeps its own first-write bookkeeping.
module clk_mode_ctrl_chk #(
    parameter int PS_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [7:0]      wr_data,
    input logic            ext_ready,
    input logic            switch_done,
    input logic            stop_req,
    input logic [7:0]      rd_data,
    input logic [1:0]      active_mode,
    input logic            mode_pending,
    input logic [PS_W-1:0] prescale
);
    logic seen_wr;
    logic lock_ext;
    logic unused_chk;

    assign unused_chk = ^{wr_data[7:5], wr_data[3:0], switch_done};

    // Observe the first write after reset and the lock it implies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_wr  <= 1'b0;
            lock_ext <= 1'b0;
        end else if (wr_en && !seen_wr) begin
            seen_wr  <= 1'b1;
            lock_ext <= ~wr_data[4];
        end
    end

    assert_once_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen_wr) |=> (rd_data[6:5] == $past(rd_data[6:5])));

    assert_ext_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ext |-> !rd_data[4]);

    assert_pending_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pending |=> (rd_data[4:3] == $past(rd_data[4:3])));

    assert_bypass_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == 2'b10 && $past(active_mode) != 2'b10) |-> $past(ext_ready));

    assert_stop_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (active_mode == $past(active_mode)));

    assert_internal_prescale_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_mode[1] |-> (prescale == PS_W'(1)));

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_data[0]);
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (.*);

// File: tb/tb_clk_mode_ctrl.sv
// Self-checking bench: behavioural reference model compared every cycle plus directed checks.
module tb_clk_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_ready = 1'b0;
    logic       switch_done = 1'b0;
    logic       stop_req = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] active_mode;
    logic       mode_pending;
    logic [6:0] prescale;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    clk_mode_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ext_ready    (ext_ready),
        .switch_done  (switch_done),
        .stop_req     (stop_req),
        .rd_data      (rd_data),
        .active_mode  (active_mode),
        .mode_pending (mode_pending),
        .prescale     (prescale)
    );

    // Reference model state
    bit m_gain, m_range, m_refs, m_ostop, m_locd, m_pend, m_once, m_first, m_lock, m_done, m_take;
    int m_mode, m_active;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gain = 0; m_range = 1; m_refs = 0; m_ostop = 1; m_locd = 0;
            m_mode = 0; m_active = 0; m_pend = 0; m_once = 0; m_first = 0; m_lock = 0;
        end else begin
            m_done = m_pend && !stop_req && ((m_mode == 2) ? ext_ready : switch_done);
            m_take = wr_en && !m_pend && !(m_lock && wr_data[4]);
            if (wr_en) begin
                m_gain = wr_data[7]; m_ostop = wr_data[2]; m_locd = wr_data[1];
                if (!m_once) begin m_range = wr_data[6]; m_refs = wr_data[5]; m_once = 1; end
                if (!m_first && !m_pend) begin m_first = 1; m_lock = !wr_data[4]; end
            end
            if (m_done) begin
                m_active = m_mode; m_pend = 0;
            end else if (m_take && int'(wr_data[4:3]) != m_active) begin
                m_pend = 1;
            end
            if (m_take) m_mode = int'(wr_data[4:3]);
        end
    end

    function automatic logic [7:0] model_rd();
        return {m_gain, m_range, m_refs, 2'(m_mode), m_ostop, m_locd, 1'b0};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one clock and compare every output against the model.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            chk("R2 model rd_data", rd_data, model_rd());
            chk("R7 model active_mode", active_mode, m_active);
            chk("R5 model mode_pending", mode_pending, m_pend);
            chk("R10 model prescale", prescale, (m_active >= 2 && !m_range) ? 64 : 1);
        end
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset rd_data", rd_data, 8'h44);
        chk("R1 reset active", active_mode, 0);
        chk("R1 reset pending", mode_pending, 0);

        wr(8'hBB);                                   // first write: range 0, refs 1, mode 11, bit0 set
        chk("R2 free bits and bit0", rd_data, 8'hBA);
        chk("R5 differing mode sets pending", mode_pending, 1);
        chk("R10 internal prescale", prescale, 1);

        wr(8'h8E);                                   // mode 01 while pending; osc-stop changes
        chk("R6 mode held, others update", rd_data, 8'hBE);

        switch_done = 1'b1; cyc(); switch_done = 1'b0;
        chk("R7 done completes", active_mode, 3);
        chk("R7 pending cleared", mode_pending, 0);
        chk("R10 external range0 prescale", prescale, 64);

        wr(8'hFE);                                   // try range 1, same mode
        chk("R3 range write-once", rd_data, 8'hBE);
        chk("R5 equal mode no pending", mode_pending, 0);

        wr(8'hB6);                                   // request bypass
        switch_done = 1'b1; cyc(); switch_done = 1'b0;
        chk("R8 done ignored for bypass", active_mode, 3);
        chk("R8 still pending", mode_pending, 1);
        ext_ready = 1'b1; cyc(); ext_ready = 1'b0;
        chk("R8 ready completes bypass", active_mode, 2);
        chk("R10 bypass prescale", prescale, 64);

        wr(8'hAE);                                   // request mode 01
        stop_req = 1'b1; switch_done = 1'b1; cyc();
        chk("R9 stop blocks completion", active_mode, 2);
        chk("R9 register unchanged", rd_data, 8'hAE);
        stop_req = 1'b0; cyc(); switch_done = 1'b0;
        chk("R7 completes after stop", active_mode, 1);
        chk("R10 internal with range0", prescale, 1);

        do_reset();
        wr(8'h08);                                   // first mode write with bit4 = 0
        switch_done = 1'b1; cyc(); switch_done = 1'b0;
        wr(8'h18);
        chk("R4 locked rejects 11", rd_data, 8'h08);
        chk("R4 no pending on reject", mode_pending, 0);
        wr(8'h00);
        chk("R4 lower mode still allowed", rd_data, 8'h00);
        switch_done = 1'b1; cyc(); switch_done = 1'b0;
        chk("R7 back to self-clocked", active_mode, 0);

        do_reset();
        wr(8'h10);                                   // first mode write with bit4 = 1
        cyc();
        ext_ready = 1'b1; cyc(); ext_ready = 1'b0;
        chk("R8 bypass after ready", active_mode, 2);
        wr(8'h08);
        switch_done = 1'b1; cyc(); switch_done = 1'b0;
        wr(8'h18);
        chk("R4 no lock allows 11", rd_data, 8'h18);
        chk("R1 bit0 reads zero", rd_data[0], 0);
        cyc();
        summary();
    end
endmodule